// File: doc/BRIEF.md
# Monochrome Glyph Expansion Engine

This engine turns one-bit-per-pixel glyph rows into 32-bit pixel writes for a true-colour frame buffer. Software programs a foreground colour, a background colour, a glyph width of 1 to 32 pixels, a packed Y/X start position and a packed Y/X step. It then writes one 32-bit word per glyph row. The engine walks the row from its most significant bit downward and emits one pixel per clock. A set bit gives the foreground colour and a clear bit gives the background colour, so the background is always drawn opaque.

When a row finishes, the stored position advances by the step. The default step of one line down lets consecutive row words stack into a glyph without rewriting the position. Images wider than 32 pixels are drawn as successive strips: software reprograms the position for each strip. While a row is being expanded, the engine refuses every register write and holds its ready output low.

Top module: `glyph_expander`

## Requirements
- R1: After reset the engine is idle, with busy and px_valid low and wr_ready high. The position is (Y=0, X=0), the width field is 0 (meaning 32 pixels) and the step is Y=1, X=0.
- R2: Selector 0 loads the foreground from wr_data[31:0] and selector 1 loads the background from wr_data[31:0]. Selector 2 loads both at once, with the foreground from wr_data[63:32] and the background from wr_data[31:0].
- R3: Selector 3 loads the width from wr_data[4:0] and ignores the higher bits. A value of 1 to 31 gives that many pixels per row, and 0 gives 32.
- R4: Selector 4 loads the position from wr_data[31:0], with Y in bits 31:16 and X in bits 15:0.
- R5: Pixel i of a row takes bit 31-i of the row word. A 1 gives the foreground colour and a 0 gives the background colour.
- R6: A row accepted at clock edge k produces pixel i during the cycle after edge k+i. That pixel is at X = position X + i (modulo 2^16) and Y = position Y.
- R7: Only the top N bits of a row word are drawn, where N is the width. The remaining bits produce no pixels.
- R8: Selector 5 loads the step, with Y step in bits 31:16 and X step in bits 15:0. When a row completes, each position field adds its step field modulo 2^16.
- R9: While busy is high, wr_ready is low and every write is ignored, including row writes (selector 6).
- R10: busy and px_valid stay high for exactly N cycles per row. The cycle after the last pixel is idle and can accept a new write.
- R11: Writes made between rows take effect on the next row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register selector (0 fg, 1 bg, 2 both colours, 3 width, 4 position, 5 step, 6 row word) |
| wr_data | input | 64 | Write data |
| wr_ready | output | 1 | High when a write is accepted |
| px_valid | output | 1 | Pixel write strobe |
| px_x | output | 16 | Pixel X coordinate |
| px_y | output | 16 | Pixel Y coordinate |
| px_color | output | 32 | Pixel colour |
| busy | output | 1 | Row expansion in progress |

## Verification
The bench sweeps every width from 1 to 32. Each row word is a different scrambled pattern, and the high width bits carry junk. This separates off-by-one errors in pixel count and bit order from width-decode mistakes, including the 0-means-32 case. All-ones and all-zeros words with distinct colours separate the foreground and background paths. Writing the position near 0xFFFF and using a non-trivial step exposes errors in the wrap and in the fieldwise add. Writes made during a row then show whether the busy gating leaks into colour or into extra pixels.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
    localparam int COORD_W = 16;
    localparam int COLOR_W = 32;
    localparam int ROW_W   = 32;
    localparam int WFLD_W  = $clog2(ROW_W);
    localparam int CNT_W   = $clog2(ROW_W + 1);
    localparam int DATA_W  = 2 * COLOR_W;

    typedef enum logic [2:0] {
        SEL_FG     = 3'd0,
        SEL_BG     = 3'd1,
        SEL_COLORS = 3'd2,
        SEL_WIDTH  = 3'd3,
        SEL_ORIGIN = 3'd4,
        SEL_STEP   = 3'd5,
        SEL_ROW    = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] x;
    } coord_t;

    typedef struct packed {
        logic               valid;
        coord_t             at;
        logic [COLOR_W-1:0] color;
    } pixel_t;

    function automatic coord_t coord_add(coord_t a, coord_t b);
        coord_t r;
        r.y = a.y + b.y;
        r.x = a.x + b.x;
        return r;
    endfunction

    function automatic logic [CNT_W-1:0] width_decode(logic [WFLD_W-1:0] f);
        return (f == '0) ? CNT_W'(ROW_W) : CNT_W'(f);
    endfunction
endpackage

// File: rtl/glyph_regs.sv
module glyph_regs
    import glyph_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  reg_sel_e            wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                row_done,
    output logic [COLOR_W-1:0]  fg,
    output logic [COLOR_W-1:0]  bg,
    output logic [CNT_W-1:0]    width,
    output coord_t              origin,
    output coord_t              step
);
    logic [WFLD_W-1:0] width_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            fg      <= '0;
            bg      <= '0;
            width_f <= '0;
            origin  <= '0;
            step    <= '{y: COORD_W'(1), x: '0};
        end else begin
            if (wr_en) begin
                unique case (wr_sel)
                    SEL_FG:     fg <= wr_data[COLOR_W-1:0];
                    SEL_BG:     bg <= wr_data[COLOR_W-1:0];
                    SEL_COLORS: begin
                        fg <= wr_data[DATA_W-1:COLOR_W];
                        bg <= wr_data[COLOR_W-1:0];
                    end
                    SEL_WIDTH:  width_f <= wr_data[WFLD_W-1:0];
                    SEL_ORIGIN: origin  <= coord_t'(wr_data[2*COORD_W-1:0]);
                    SEL_STEP:   step    <= coord_t'(wr_data[2*COORD_W-1:0]);
                    default:    ;
                endcase
            end
            if (row_done) origin <= coord_add(origin, step);
        end
    end

    assign width = width_decode(width_f);

    assert_no_write_during_row_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && row_done));

    assert_width_legal_R3: assert property (@(posedge clk) disable iff (rst)
        (width >= CNT_W'(1)) && (width <= CNT_W'(ROW_W)));
endmodule

// File: rtl/glyph_row.sv
module glyph_row
    import glyph_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [ROW_W-1:0]    row_word,
    input  logic [CNT_W-1:0]    width,
    input  coord_t              origin,
    input  logic [COLOR_W-1:0]  fg,
    input  logic [COLOR_W-1:0]  bg,
    output logic                busy,
    output logic                row_done,
    output pixel_t              pix
);
    logic [ROW_W-1:0] shreg;
    logic [CNT_W-1:0] idx;

    assign row_done = busy && (idx == width - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            shreg <= '0;
            idx   <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            shreg <= row_word;
            idx   <= '0;
        end else if (busy) begin
            shreg <= {shreg[ROW_W-2:0], 1'b0};
            idx   <= idx + CNT_W'(1);
            if (row_done) busy <= 1'b0;
        end
    end

    always_comb begin
        pix.valid = busy;
        pix.at.y  = origin.y;
        pix.at.x  = origin.x + COORD_W'(idx);
        pix.color = shreg[ROW_W-1] ? fg : bg;
    end

    assert_idx_in_range_R7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx < width));

    assert_row_ends_R10: assert property (@(posedge clk) disable iff (rst)
        row_done |=> !busy);

    assert_pixel_advance_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && !row_done) |=> (busy && pix.at.x == $past(pix.at.x) + COORD_W'(1)
                                 && pix.at.y == $past(pix.at.y)));

    assert_start_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
endmodule

// File: rtl/glyph_expander.sv
module glyph_expander
    import glyph_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [2:0]          wr_sel,
    input  logic [DATA_W-1:0]   wr_data,
    output logic                wr_ready,
    output logic                px_valid,
    output logic [COORD_W-1:0]  px_x,
    output logic [COORD_W-1:0]  px_y,
    output logic [COLOR_W-1:0]  px_color,
    output logic                busy
);
    reg_sel_e           sel;
    logic               accept;
    logic               start;
    logic               cfg_wr;
    logic               row_done;
    logic [COLOR_W-1:0] fg;
    logic [COLOR_W-1:0] bg;
    logic [CNT_W-1:0]   width;
    coord_t             origin;
    coord_t             step;
    pixel_t             pix;

    assign sel      = reg_sel_e'(wr_sel);
    assign wr_ready = !busy;
    assign accept   = wr_en && wr_ready;
    assign start    = accept && (sel == SEL_ROW);
    assign cfg_wr   = accept && (sel != SEL_ROW);

    glyph_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (cfg_wr),
        .wr_sel   (sel),
        .wr_data  (wr_data),
        .row_done (row_done),
        .fg       (fg),
        .bg       (bg),
        .width    (width),
        .origin   (origin),
        .step     (step)
    );

    glyph_row u_row (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .row_word (wr_data[ROW_W-1:0]),
        .width    (width),
        .origin   (origin),
        .fg       (fg),
        .bg       (bg),
        .busy     (busy),
        .row_done (row_done),
        .pix      (pix)
    );

    assign px_valid = pix.valid;
    assign px_x     = pix.at.x;
    assign px_y     = pix.at.y;
    assign px_color = pix.color;

    assert_busy_from_row_write_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_en && wr_sel == 3'd6));

    assert_colour_source_R5: assert property (@(posedge clk) disable iff (rst)
        px_valid |-> (px_color == fg || px_color == bg));

    assert_row_origin_held_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !row_done) |=> $stable(origin));
endmodule

// File: tb/glyph_expander_bench.sv
`timescale 1ns/1ps
module glyph_expander_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [63:0] wr_data;
    logic        wr_ready, px_valid, busy;
    logic [15:0] px_x, px_y;
    logic [31:0] px_color;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_fg = 0, m_bg = 0;
    int          m_w = 0;
    logic [15:0] m_x = 0, m_y = 0, m_sx = 0, m_sy = 1;

    always #2.5 clk = ~clk;

    glyph_expander u_glyph_expander (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_ready(wr_ready), .px_valid(px_valid), .px_x(px_x), .px_y(px_y),
        .px_color(px_color), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            3'd0: m_fg = d[31:0];
            3'd1: m_bg = d[31:0];
            3'd2: begin m_fg = d[63:32]; m_bg = d[31:0]; end
            3'd3: m_w = int'(d[4:0]);
            3'd4: begin m_y = d[31:16]; m_x = d[15:0]; end
            3'd5: begin m_sy = d[31:16]; m_sx = d[15:0]; end
            default: ;
        endcase
    endtask

    // poke: 0 none, 1 fg write during row, 2 row write during row
    task automatic run_row(input logic [31:0] word, input int poke);
        int n;
        n = (m_w == 0) ? 32 : m_w;
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd6; wr_data = {32'h0, word};
        for (int i = 0; i < n; i++) begin
            logic [31:0] ec;
            @(negedge clk);
            wr_en = 1'b0;
            ec = word[31-i] ? m_fg : m_bg;
            chk(px_valid && busy && !wr_ready, "R10 busy/valid during row", {busy, px_valid, wr_ready}, 3'b110);
            chk(px_x == m_x + 16'(i), "R6 pixel x", px_x, m_x + 16'(i));
            chk(px_y == m_y, "R6 pixel y", px_y, m_y);
            chk(px_color == ec, "R5 pixel colour", px_color, ec);
            if (i == 0 && n > 1 && poke == 1) begin wr_en = 1'b1; wr_sel = 3'd0; wr_data = 64'h0BAD_0BAD; end
            if (i == 0 && n > 1 && poke == 2) begin wr_en = 1'b1; wr_sel = 3'd6; wr_data = 64'hFFFF_FFFF; end
        end
        @(negedge clk);
        wr_en = 1'b0;
        chk(!px_valid && !busy && wr_ready, "R7 R10 idle after N pixels", {busy, px_valid, wr_ready}, 3'b001);
        m_x = m_x + m_sx;
        m_y = m_y + m_sy;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = 3'd0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !px_valid && wr_ready, "R1 reset idle", {busy, px_valid, wr_ready}, 3'b001);

        // R1 defaults: width 32, origin (0,0), step Y+1; R2 combined colour load
        wr(3'd2, 64'h00FF_8800_0000_1122);
        run_row(32'hF0F0_1234, 0);
        run_row(32'h8000_0001, 0);

        // R3 R5 R6 R7 sweep of all widths, junk in high width bits and low row bits
        for (int w = 1; w <= 32; w++) begin
            logic [31:0] word;
            word = (32'h9E37_79B9 * w) ^ (32'hFFFF_FFFF >> w);
            wr(3'd3, {32'h0, 27'h5A5_A5A5, 5'(w)});
            if (w % 3 == 0) wr(3'd0, {32'h0, 32'hC0DE_0000 + 32'(w)});
            if (w % 3 == 1) wr(3'd1, {32'h0, 32'h0B0B_0000 + 32'(w)});
            if (w % 4 == 0) wr(3'd4, {32'h0, 16'(w * 7), 16'(w * 40)});
            run_row(word, 0);
        end

        // R5 all ones / all zeros
        wr(3'd2, 64'hAAAA_AAAA_5555_5555);
        wr(3'd3, 64'd8);
        run_row(32'hFFFF_FFFF, 0);
        run_row(32'h0000_0000, 0);

        // R7 only top bits used
        wr(3'd3, 64'd3);
        run_row(32'h1FFF_FFFF, 0);

        // R8 custom step with wrap in both fields, R4 position
        wr(3'd4, {32'h0, 16'hFFFF, 16'hFFFE});
        wr(3'd5, {32'h0, 16'h0003, 16'hFFF0});
        wr(3'd3, 64'd4);
        run_row(32'hA000_0000, 0);
        run_row(32'h5000_0000, 0);
        run_row(32'hC000_0000, 0);

        // R9 writes during a row are ignored; R11 next row uses old fg
        wr(3'd5, {32'h0, 16'h0001, 16'h0000});
        wr(3'd2, 64'h1111_1111_2222_2222);
        wr(3'd3, 64'd6);
        run_row(32'hFC00_0000, 1);
        run_row(32'hFC00_0000, 2);
        run_row(32'hA800_0000, 0);

        // R11 changes between rows take effect
        wr(3'd0, 64'h7777_7777);
        wr(3'd3, 64'd0);
        run_row(32'hFFFF_0000, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule